// File: doc/BRIEF.md
# Banked Register Address Generator

This block produces the physical register-file index for a small controller datapath whose data memory is split into banks. Every access names an 8-bit logical address. The top three bits pick a bank, bit 4 picks between a common window and a private window, and the low four bits are an offset. In direct mode the instruction gives only bit 4 and the offset, and a bank-select register supplies the top three bits. In indirect mode a pointer register gives all eight bits, and the bank-select register has no effect.

Logical addresses with bit 4 clear all reach one set of 16 registers, whatever the bank bits hold. That set contains the hardware registers and a few general registers that every bank can reach. Addresses with bit 4 set reach 16 registers that belong to the selected bank alone. This gives 16 + 8×16 = 144 physical locations. A behavioural register file is included so that the mapping can be seen at the ports. Reads return data in the same cycle. Writes take effect at the clock edge.

Top module: `bkag_top`

## Requirements
- R1: In direct mode (`mode_ind`=0), `eff_addr[4:0]` equals `instr_addr` and `eff_addr[7:5]` equals the bank-select register.
- R2: In indirect mode (`mode_ind`=1), `eff_addr` equals the pointer register in all eight bits, and the bank-select register has no effect on it.
- R3: When `eff_addr[4]` is 0, `in_common` is 1 and `phys_idx` equals `eff_addr[3:0]`. The same physical register is reached from every bank.
- R4: When `eff_addr[4]` is 1, `in_common` is 0 and `phys_idx` equals 16 + 16×`eff_addr[7:5]` + `eff_addr[3:0]`.
- R5: `rd_data` shows the register at `phys_idx` in the same cycle, with no clock edge in between.
- R6: When `wr_en` is 1, the register at `phys_idx` takes `wr_data` at the rising clock edge. When `wr_en` is 0, no register changes.
- R7: A write to the bank-select register (`bank_we`, `bank_wd`) is used by direct accesses from the next cycle. The access in the same cycle still uses the old bank.
- R8: A write to the pointer register (`ptr_we`, `ptr_wd`) is used by indirect accesses from the next cycle.
- R9: While `rst_n` is low, the bank-select register, the pointer register and every register-file location are cleared to zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_ind | input | 1 | 1 = indirect through the pointer, 0 = direct |
| instr_addr | input | 5 | Direct address field: bit 4 window select, bits 3:0 offset |
| bank_we | input | 1 | Load enable for the bank-select register |
| bank_wd | input | 3 | New bank-select value |
| ptr_we | input | 1 | Load enable for the pointer register |
| ptr_wd | input | 8 | New pointer value |
| wr_en | input | 1 | Register-file write enable |
| wr_data | input | 8 | Register-file write data |
| rd_data | output | 8 | Register-file read data at the current index |
| eff_addr | output | 8 | Logical address in use this cycle |
| phys_idx | output | 8 | Physical register index, 0 to 143 |
| in_common | output | 1 | 1 when the access falls in the common window |

## Verification
The hardest case to produce is aliasing. A value must be written through one bank's view of the common window and read back through another bank's view, and private writes in one bank must leave all other banks untouched. The stimulus first fills all eight private windows with distinct values, one bank at a time. It then writes a common register under one bank and reads it under another. Finally it sweeps all 256 logical addresses through the pointer, so that every alias and every private location is compared with the reference model. The ordering of a bank change against a direct access in the same cycle is forced by a directed cycle, and a long random run follows.

// File: rtl/bkag_pkg.sv
package bkag_pkg;
   typedef enum logic {
      WIN_COMMON  = 1'b0,
      WIN_PRIVATE = 1'b1
   } win_t;

   typedef enum logic {
      AM_DIRECT   = 1'b0,
      AM_INDIRECT = 1'b1
   } amode_t;
endpackage

// File: rtl/bkag_sel_regs.sv
module bkag_sel_regs #(
   parameter int BANK_W = 3,
   parameter int ADDR_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bank_we,
   input  logic [BANK_W-1:0] bank_wd,
   input  logic              ptr_we,
   input  logic [ADDR_W-1:0] ptr_wd,
   output logic [BANK_W-1:0] bank_q,
   output logic [ADDR_W-1:0] ptr_q
);
   initial begin : p_param_chk
      assert (BANK_W >= 1 && ADDR_W > BANK_W)
         else $error("bkag_sel_regs: bad widths");
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         bank_q <= '0;
      end else if (bank_we) begin
         bank_q <= bank_wd;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ptr_q <= '0;
      end else if (ptr_we) begin
         ptr_q <= ptr_wd;
      end
   end

   // R7: the bank register changes only through a load
   p_bank_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !bank_we |=> $stable(bank_q));
   p_bank_load_r7: assert property (@(posedge clk) disable iff (!rst_n)
      bank_we |=> bank_q == $past(bank_wd));
   // R8: the pointer register changes only through a load
   p_ptr_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !ptr_we |=> $stable(ptr_q));
   p_ptr_load_r8: assert property (@(posedge clk) disable iff (!rst_n)
      ptr_we |=> ptr_q == $past(ptr_wd));
endmodule

// File: rtl/bkag_addr_map.sv
module bkag_addr_map
   import bkag_pkg::*;
#(
   parameter int OFS_W  = 4,
   parameter int BANK_W = 3,
   localparam int ADDR_W = BANK_W + 1 + OFS_W,
   localparam int IDX_W  = BANK_W + 1 + OFS_W
) (
   input  amode_t            mode,
   input  logic [OFS_W:0]    field,
   input  logic [BANK_W-1:0] bank_q,
   input  logic [ADDR_W-1:0] ptr_q,
   output logic [ADDR_W-1:0] eff_addr,
   output logic [IDX_W-1:0]  phys_idx,
   output win_t              win
);
   logic [BANK_W-1:0] sel_bank;
   logic [OFS_W-1:0]  sel_ofs;
   logic [BANK_W:0]   slot;

   initial begin : p_param_chk
      assert (OFS_W >= 1 && BANK_W >= 1)
         else $error("bkag_addr_map: bad widths");
   end

   // logical address: pointer in indirect mode, bank register + field otherwise
   always_comb begin
      if (mode == AM_INDIRECT) eff_addr = ptr_q;
      else                     eff_addr = {bank_q, field};
   end

   assign sel_bank = eff_addr[ADDR_W-1 -: BANK_W];
   assign sel_ofs  = eff_addr[OFS_W-1:0];
   assign win      = win_t'(eff_addr[OFS_W]);

   // slot 0 is the shared window, slot b+1 is the private window of bank b
   always_comb begin
      if (win == WIN_COMMON) slot = '0;
      else                   slot = {1'b0, sel_bank} + {{BANK_W{1'b0}}, 1'b1};
      phys_idx = {slot, sel_ofs};
   end
endmodule

// File: rtl/bkag_regfile.sv
module bkag_regfile #(
   parameter int DATA_W   = 8,
   parameter int DEPTH    = 144,
   parameter int IDX_W    = 8,
   parameter bit RF_CLEAR = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              we,
   input  logic [IDX_W-1:0]  idx,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] rdata
);
   logic [DATA_W-1:0] mem [DEPTH];

   initial begin : p_param_chk
      assert (DEPTH >= 2 && DEPTH <= (1 << IDX_W))
         else $error("bkag_regfile: depth does not fit index");
   end

   for (genvar i = 0; i < DEPTH; i++) begin : g_row
      logic hit;
      assign hit = we && (idx == IDX_W'(i));
      if (RF_CLEAR) begin : g_clr
         always_ff @(posedge clk) begin
            if (!rst_n)   mem[i] <= '0;
            else if (hit) mem[i] <= wdata;
         end
      end else begin : g_noclr
         always_ff @(posedge clk) begin
            if (hit) mem[i] <= wdata;
         end
      end
   end

   assign rdata = mem[idx];

   // R6: a write lands in the addressed row; no write leaves that row intact
   p_write_r6: assert property (@(posedge clk) disable iff (!rst_n)
      we |=> mem[$past(idx)] == $past(wdata));
   p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !we |=> mem[$past(idx)] == $past(rdata));
endmodule

// File: rtl/bkag_top.sv
module bkag_top
   import bkag_pkg::*;
#(
   parameter int OFS_W    = 4,
   parameter int BANK_W   = 3,
   parameter int DATA_W   = 8,
   parameter bit RF_CLEAR = 1'b1,
   localparam int ADDR_W  = BANK_W + 1 + OFS_W,
   localparam int WIN     = 1 << OFS_W,
   localparam int NBANK   = 1 << BANK_W,
   localparam int DEPTH   = WIN * (NBANK + 1),
   localparam int IDX_W   = BANK_W + 1 + OFS_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              mode_ind,
   input  logic [OFS_W:0]    instr_addr,
   input  logic              bank_we,
   input  logic [BANK_W-1:0] bank_wd,
   input  logic              ptr_we,
   input  logic [ADDR_W-1:0] ptr_wd,
   input  logic              wr_en,
   input  logic [DATA_W-1:0] wr_data,
   output logic [DATA_W-1:0] rd_data,
   output logic [ADDR_W-1:0] eff_addr,
   output logic [IDX_W-1:0]  phys_idx,
   output logic              in_common
);
   logic [BANK_W-1:0] bank_q;
   logic [ADDR_W-1:0] ptr_q;
   win_t              win;
   amode_t            mode;

   assign mode      = amode_t'(mode_ind);
   assign in_common = (win == WIN_COMMON);

   bkag_sel_regs #(.BANK_W(BANK_W), .ADDR_W(ADDR_W)) u_regs (
      .clk     (clk),
      .rst_n   (rst_n),
      .bank_we (bank_we),
      .bank_wd (bank_wd),
      .ptr_we  (ptr_we),
      .ptr_wd  (ptr_wd),
      .bank_q  (bank_q),
      .ptr_q   (ptr_q)
   );

   bkag_addr_map #(.OFS_W(OFS_W), .BANK_W(BANK_W)) u_map (
      .mode     (mode),
      .field    (instr_addr),
      .bank_q   (bank_q),
      .ptr_q    (ptr_q),
      .eff_addr (eff_addr),
      .phys_idx (phys_idx),
      .win      (win)
   );

   bkag_regfile #(.DATA_W(DATA_W), .DEPTH(DEPTH), .IDX_W(IDX_W),
                  .RF_CLEAR(RF_CLEAR)) u_rf (
      .clk   (clk),
      .rst_n (rst_n),
      .we    (wr_en),
      .idx   (phys_idx),
      .wdata (wr_data),
      .rdata (rd_data)
   );

   // R1: the direct field passes through to the low address bits
   p_direct_field_r1: assert property (@(posedge clk) disable iff (!rst_n)
      !mode_ind |-> eff_addr[OFS_W:0] == instr_addr);
   // R7: a bank load is seen by the direct access of the following cycle
   p_direct_bank_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (!mode_ind && $past(bank_we)) |-> eff_addr[ADDR_W-1 -: BANK_W] == $past(bank_wd));
   // R2: a pointer load fully defines the next indirect address
   p_indirect_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_ind && $past(ptr_we)) |-> eff_addr == $past(ptr_wd));
   // R3: the common window stays below the first private slot
   p_common_r3: assert property (@(posedge clk) disable iff (!rst_n)
      !eff_addr[OFS_W] |-> (in_common && phys_idx < IDX_W'(WIN)));
   // R4: private accesses stay above the common window and keep the offset
   p_private_r4: assert property (@(posedge clk) disable iff (!rst_n)
      eff_addr[OFS_W] |-> (!in_common && phys_idx >= IDX_W'(WIN)
                           && phys_idx[OFS_W-1:0] == eff_addr[OFS_W-1:0]));
endmodule

// File: tb/tb_bkag_top.sv
`timescale 1ns/1ps
module tb_bkag_top;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       mode_ind = 1'b0;
   logic [4:0] instr_addr = '0;
   logic       bank_we = 1'b0;
   logic [2:0] bank_wd = '0;
   logic       ptr_we = 1'b0;
   logic [7:0] ptr_wd = '0;
   logic       wr_en = 1'b0;
   logic [7:0] wr_data = '0;
   logic [7:0] rd_data, eff_addr, phys_idx;
   logic       in_common;

   int checks = 0;
   int errors = 0;
   bit done = 0;

   int ref_mem [144];
   int ref_bank = 0;
   int ref_ptr = 0;

   always #2 clk = ~clk;

   bkag_top dut (
      .clk(clk), .rst_n(rst_n), .mode_ind(mode_ind), .instr_addr(instr_addr),
      .bank_we(bank_we), .bank_wd(bank_wd), .ptr_we(ptr_we), .ptr_wd(ptr_wd),
      .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data), .eff_addr(eff_addr),
      .phys_idx(phys_idx), .in_common(in_common)
   );

   task automatic check(input string tag, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
      end
   endtask

   // one cycle: drive at the falling edge, compare, then advance the model at the rising edge
   task automatic cyc(input bit ind, input int ia, input bit bwe, input int bwd,
                      input bit pwe, input int pwd, input bit we, input int wd);
      int e, p;
      mode_ind = ind; instr_addr = 5'(ia);
      bank_we = bwe; bank_wd = 3'(bwd);
      ptr_we = pwe; ptr_wd = 8'(pwd);
      wr_en = we; wr_data = 8'(wd);
      #1;
      e = ind ? ref_ptr : (ref_bank * 32 + (ia & 31));
      p = ((e >> 4) & 1) ? (16 + (e >> 5) * 16 + (e & 15)) : (e & 15);
      check(ind ? "R2" : "R1", int'(eff_addr), e);
      check(((e >> 4) & 1) ? "R4" : "R3", int'(phys_idx), p);
      check(((e >> 4) & 1) ? "R4" : "R3", int'(in_common), ((e >> 4) & 1) ? 0 : 1);
      check("R5", int'(rd_data), ref_mem[p]);
      @(posedge clk);
      if (we)  ref_mem[p] = wd & 255;
      if (bwe) ref_bank = bwd & 7;
      if (pwe) ref_ptr = pwd & 255;
      @(negedge clk);
   endtask

   initial begin
      #600000;
      errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      if (!done) begin
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      for (int i = 0; i < 144; i++) ref_mem[i] = 0;
      // R9: outputs during reset and right after it
      repeat (3) @(negedge clk);
      mode_ind = 1'b1; #1;
      check("R9", int'(eff_addr), 0);
      rst_n = 1'b1;
      @(negedge clk);
      mode_ind = 1'b0; instr_addr = 5'h1a; #1;
      check("R9", int'(eff_addr), 8'h1a);
      check("R9", int'(rd_data), 0);

      // fill every private window, one bank at a time
      for (int b = 0; b < 8; b++) begin
         cyc(0, 0, 1, b, 0, 0, 0, 0);
         for (int o = 0; o < 16; o++) cyc(0, 16 + o, 0, 0, 0, 0, 1, b * 16 + o + 1);
      end
      // R3: write common register under bank 3, read it under bank 6
      cyc(0, 0, 1, 3, 0, 0, 0, 0);
      cyc(0, 5, 0, 0, 0, 0, 1, 8'ha5);
      cyc(0, 0, 1, 6, 0, 0, 0, 0);
      cyc(0, 5, 0, 0, 0, 0, 0, 0);
      check("R3", int'(rd_data), 8'ha5);
      // R6: write enable low leaves the register unchanged
      cyc(0, 5, 0, 0, 0, 0, 0, 8'hff);
      #1; check("R6", int'(rd_data), 8'ha5);
      // R7: bank load in the same cycle as a direct access
      mode_ind = 0; instr_addr = 5'h12; bank_we = 1; bank_wd = 3'd2; #1;
      check("R7", int'(eff_addr), 8'hd2);
      @(posedge clk); ref_bank = 2; @(negedge clk);
      bank_we = 0; #1;
      check("R7", int'(eff_addr), 8'h52);
      check("R7", int'(rd_data), 2 * 16 + 2 + 1);
      // R8 and R2: pointer load, then bank change ignored in indirect mode
      cyc(1, 0, 0, 0, 1, 8'h9c, 0, 0);
      #1; check("R8", int'(eff_addr), 8'h9c);
      cyc(1, 0, 1, 7, 0, 0, 0, 0);
      #1; check("R2", int'(eff_addr), 8'h9c);
      check("R2", int'(rd_data), 4 * 16 + 12 + 1);
      // sweep all logical addresses through the pointer
      for (int a = 0; a < 256; a++) begin
         cyc(1, 0, 0, 0, 1, a, 0, 0);
         cyc(1, 0, 0, 0, 0, 0, 0, 0);
      end
      // random traffic
      for (int n = 0; n < 4000; n++) begin
         cyc(($urandom % 3) == 0, $urandom % 32, ($urandom % 5) == 0, $urandom % 8,
             ($urandom % 4) == 0, $urandom % 256, ($urandom % 2) == 0, $urandom % 256);
      end
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule